// File: doc/BRIEF.md
# Command Frame Builder

The block turns a short command request into a framed byte stream for a downstream UART transmitter. A requester first writes the payload bytes into a small internal buffer, one byte per cycle, by index. It then pulses `start` together with a 4-bit command identifier and a payload length from 0 to 15. The block sends four kinds of byte in this order: a fixed start marker, a header byte, the payload bytes from buffer index 0 upwards, and a one-byte checksum. Each byte goes out over a valid/ready handshake.

The header byte holds the command identifier in its upper nibble and the payload length in its lower nibble. The checksum is the modulo-256 sum of the header byte and every payload byte. The start marker is not part of that sum. A frame is therefore always three bytes longer than its payload. The block takes a new request only while it is idle. While a frame is in flight it ignores further start pulses and buffer writes.

Top module: `cmd_framer`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted start, `busy` and `byte_valid` are low.
- R2: The first byte of every frame equals the parameter `SOF_BYTE` (default 0x02).
- R3: The second byte is the header: bits 7:4 carry `cmd_id` and bits 3:0 carry `pay_len`, both as sampled with the accepted start.
- R4: After the header come exactly `pay_len` payload bytes, taken from buffer indices 0, 1, ... `pay_len`-1 in that order.
- R5: The last byte is the checksum, the 8-bit truncated sum of the header byte and all payload bytes, with carries out of bit 7 dropped.
- R6: A frame consists of exactly `pay_len`+3 accepted bytes. A zero-length request gives three bytes, and its checksum equals its header.
- R7: A byte is consumed only on a cycle in which `byte_valid` and `byte_ready` are both high. While `byte_ready` is low, `byte_valid` stays high and `byte_data` holds its value.
- R8: `busy` rises in the cycle after an accepted start. It stays high until the checksum byte is accepted and is low in the following cycle.
- R9: A `start` pulse while `busy` is high has no effect on the frame in flight, and it does not begin another frame.
- R10: A buffer write (`load_en`) while `busy` is high is ignored. The payload sent is the one loaded before the start.
- R11: `byte_valid` is high in the cycle after an accepted start, presenting the start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Write one payload byte into the buffer |
| load_addr | input | 4 | Buffer index to write |
| load_data | input | 8 | Payload byte to write |
| start | input | 1 | Request a frame (taken only when idle) |
| cmd_id | input | 4 | Command identifier for the request |
| pay_len | input | 4 | Number of payload bytes, 0 to 15 |
| busy | output | 1 | Frame in flight |
| byte_valid | output | 1 | Byte offered downstream |
| byte_data | output | 8 | Byte being offered |
| byte_ready | input | 1 | Downstream takes the byte this cycle |

## Verification
Some rules are checked by assertions on every cycle. A stalled byte must keep its valid and its value. An accepted start must raise busy and valid in the next cycle. Each frame must open with the start marker. Busy may fall only after a handshake, and a start while busy must not end the frame. The bench alone shows the byte-level content of each frame. That content is the header packing, the payload order, the truncated checksum including carry wrap, and the exact count of len+3 bytes. The bench also shows that start pulses and buffer writes during a frame leave the transmitted bytes unchanged. It compares every byte against values computed from random payloads under random backpressure.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SOF  = 3'd1,
    ST_HDR  = 3'd2,
    ST_PAY  = 3'd3,
    ST_SUM  = 3'd4
  } fr_state_e;

  function automatic logic [7:0] add8(input logic [7:0] a, input logic [7:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/cmd_framer_rst_sync.sv
module cmd_framer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cmd_framer_payload_buf.sv
module cmd_framer_payload_buf #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[g] <= '0;
      else if (hit) entry_q[g] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_addr];

endmodule

// File: rtl/cmd_framer_seq.sv
module cmd_framer_seq
  import cmd_framer_pkg::*;
#(
  parameter int                ID_W     = 4,
  parameter int                LEN_W    = 4,
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SOF_BYTE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              byte_ready,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [LEN_W-1:0]  rd_addr,
  output logic              busy,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);

  localparam int HDR_W = ID_W + LEN_W;

  fr_state_e         state_q, state_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] sum_q, sum_d;
  logic [BYTE_W-1:0] header;
  logic              xfer;
  logic              take;

  assign header     = BYTE_W'({id_q, len_q});
  assign byte_valid = (state_q != ST_IDLE);
  assign busy       = byte_valid;
  assign xfer       = byte_valid && byte_ready;
  assign take       = (state_q == ST_IDLE) && start;
  assign rd_addr    = idx_q;

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    len_d   = len_q;
    idx_d   = idx_q;
    sum_d   = sum_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          id_d    = cmd_id;
          len_d   = pay_len;
          idx_d   = '0;
          state_d = ST_SOF;
        end
      end
      ST_SOF: begin
        if (xfer) state_d = ST_HDR;
      end
      ST_HDR: begin
        if (xfer) begin
          sum_d   = header;
          state_d = (len_q == '0) ? ST_SUM : ST_PAY;
        end
      end
      ST_PAY: begin
        if (xfer) begin
          sum_d = add8(sum_q, rd_data);
          idx_d = idx_q + 1'b1;
          if (idx_q == len_q - 1'b1) state_d = ST_SUM;
        end
      end
      ST_SUM: begin
        if (xfer) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_SOF:  byte_data = SOF_BYTE;
      ST_HDR:  byte_data = header;
      ST_PAY:  byte_data = rd_data;
      ST_SUM:  byte_data = sum_q;
      default: byte_data = '0;
    endcase
  end

  logic upd_cfg, upd_idx, upd_sum;
  assign upd_cfg = take;
  assign upd_idx = take || (xfer && state_q == ST_PAY);
  assign upd_sum = xfer && (state_q == ST_HDR || state_q == ST_PAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      sum_q   <= '0;
    end else begin
      state_q <= state_d;
      if (upd_cfg) begin
        id_q  <= id_d;
        len_q <= len_d;
      end
      if (upd_idx) idx_q <= idx_d;
      if (upd_sum) sum_q <= sum_d;
    end
  end

  if (HDR_W != BYTE_W) begin : g_width_check
    initial $error("header fields must fill one byte");
  end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int                ID_W     = 4,
  parameter int                LEN_W    = 4,
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SOF_BYTE = 8'h02,
  parameter int                RST_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LEN_W-1:0]  load_addr,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              start,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [LEN_W-1:0]  pay_len,
  output logic              busy,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  input  logic              byte_ready
);

  logic              rst_sync_n;
  logic              buf_wr;
  logic [LEN_W-1:0]  rd_addr;
  logic [BYTE_W-1:0] rd_data;

  cmd_framer_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign buf_wr = load_en && !busy;

  cmd_framer_payload_buf #(.BYTE_W(BYTE_W), .ADDR_W(LEN_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (buf_wr),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cmd_framer_seq #(
    .ID_W(ID_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W), .SOF_BYTE(SOF_BYTE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .cmd_id     (cmd_id),
    .pay_len    (pay_len),
    .byte_ready (byte_ready),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

endmodule

// File: rtl/cmd_framer_chk.sv
module cmd_framer_chk #(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SOF_BYTE = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic [BYTE_W-1:0] byte_data
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && byte_valid);

  assert_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> byte_data == SOF_BYTE);

  assert_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(byte_valid && byte_ready));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !byte_ready |=> busy);

endmodule

bind cmd_framer cmd_framer_chk #(.BYTE_W(BYTE_W), .SOF_BYTE(SOF_BYTE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_data  (byte_data)
);

// File: tb/sim_cmd_framer.sv
`timescale 1ns/1ps
module sim_cmd_framer;

  logic       clk;
  logic       rst_n;
  logic       load_en;
  logic [3:0] load_addr;
  logic [7:0] load_data;
  logic       start;
  logic [3:0] cmd_id;
  logic [3:0] pay_len;
  logic       busy;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_ready;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  cmd_framer u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .start(start), .cmd_id(cmd_id), .pay_len(pay_len),
    .busy(busy), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [7:0] hdr_of(input logic [3:0] id, input logic [3:0] len);
    return {id, len};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [3:0] id, input logic [3:0] len,
                           input int stall_pct, input bit inject, input bit all_ff);
    logic [7:0] pay [16];
    logic [7:0] exp [19];
    logic [7:0] sum;
    logic [7:0] prev_data;
    bit         prev_stall;
    int         n;
    int         guard;
    string      tag;
    for (int i = 0; i < 16; i++) pay[i] = all_ff ? 8'hFF : 8'($urandom);
    // load buffer while idle
    for (int i = 0; i < int'(len); i++) begin
      @(negedge clk);
      load_en = 1; load_addr = 4'(i); load_data = pay[i];
    end
    @(negedge clk);
    load_en = 0;
    exp[0] = 8'h02;
    exp[1] = hdr_of(id, len);
    sum = exp[1];
    for (int i = 0; i < int'(len); i++) begin
      exp[2+i] = pay[i];
      sum = sum + pay[i];
    end
    exp[int'(len)+2] = sum;
    start = 1; cmd_id = id; pay_len = len;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    chk(byte_valid === 1'b1, "R11 valid after start", byte_valid, 1);
    n = 0; guard = 0; prev_stall = 0; prev_data = 0;
    while (n < int'(len) + 3 && guard < 5000) begin
      byte_ready = (($urandom % 100) >= stall_pct);
      if (inject && guard == 0) begin
        start = 1; cmd_id = ~id; pay_len = 4'd15;
        load_en = 1; load_addr = (len == 0) ? 4'd0 : len - 1'b1;
        load_data = ~pay[(len == 0) ? 0 : int'(len) - 1];
      end
      if (prev_stall) begin
        chk(byte_valid === 1'b1, "R7 valid held", byte_valid, 1);
        chk(byte_data === prev_data, "R7 data held", byte_data, prev_data);
      end
      chk(busy === 1'b1, "R8 busy in frame", busy, 1);
      if (byte_valid && byte_ready) begin
        if (n == 0) tag = "R2 marker";
        else if (n == 1) tag = inject ? "R9 header" : "R3 header";
        else if (n == int'(len) + 2) tag = (len == 0) ? "R6 checksum" : "R5 checksum";
        else tag = inject ? "R10 payload" : "R4 payload";
        chk(byte_data === exp[n], tag, byte_data, exp[n]);
        n++;
      end
      prev_stall = byte_valid && !byte_ready;
      prev_data  = byte_data;
      @(negedge clk);
      start = 0; load_en = 0;
      guard++;
    end
    byte_ready = 0;
    chk(n == int'(len) + 3, "R6 byte count", n, int'(len) + 3);
    chk(busy === 1'b0 && byte_valid === 1'b0, "R8 idle after checksum", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 no restart", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R8 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 0; load_en = 0; load_addr = 0; load_data = 0;
    start = 0; cmd_id = 0; pay_len = 0; byte_ready = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && byte_valid === 1'b0, "R1 reset", busy, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && byte_valid === 1'b0, "R1 after reset", byte_valid, 0);
    run_frame(4'h3, 4'd0, 0, 0, 0);    // R6 zero length
    run_frame(4'hA, 4'd15, 50, 0, 1);  // R5 carry wrap
    run_frame(4'h5, 4'd1, 30, 1, 0);   // R9 R10 injection
    run_frame(4'hF, 4'd8, 60, 1, 0);
    for (int k = 0; k < 25; k++)
      run_frame(4'($urandom), 4'($urandom), int'($urandom % 70), bit'($urandom), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule